// File: doc/BRIEF.md
# Run-Time Sized Banked Register File

This block is the general-purpose register file of a pipelined processor: 32 registers of 32 bits, with two combinational read ports and one write port for the pipeline. The storage is built as four banks of eight registers. Before a program starts, a register-count setting says how many registers the program needs. From that setting the block powers up only the lowest banks that cover the request. It also derives a core count: how many register sets of that size fit into the full file. A surrounding system uses that count to place copies of the datapath.

A debug port reaches every register, the count setting and the core count through a flat special-register address space. It uses a small operation code for read and write. A run input locks the configuration while a program executes. Debug writes and pipeline writes can land in the same cycle. When both target the same register, the pipeline wins and the debug side is told through a one-cycle error pulse.

Top module: `scalable_regfile`

## Requirements
- R1: Register n (0 to 31) lives in bank n/8. The read ports `rd_data_a`/`rd_data_b` show the addressed register combinationally. A pipeline write (`wr_en`, `wr_addr`, `wr_data`) updates the register at the rising clock edge.
- R2: Register 0 reads as zero on both pipeline ports and on the debug port. Pipeline and debug writes to it leave it at zero.
- R3: When a write lands on a register in the current cycle, a pipeline read of that register in the same cycle returns the new data.
- R4: The debug code 0x4 with `dbg_addr` = 1024+n drives register n onto `dbg_rdata` combinationally, whatever the bank enables are. The code 0x5 with that address stores `dbg_wdata` into register n at the clock edge. Any other code changes nothing, and `dbg_rdata` is zero whenever the code is not 0x4.
- R5: A 0x5 write to address 1056 sets the register count, which reads back at address 1056. Values up to 8 (including 0) give 8, values 9 to 16 give 16, and all values from 17 up give 32.
- R6: `bank_en` bit k is 1 exactly when bank k is enabled. The enabled banks are the lowest count/8 banks: 8 gives 0001, 16 gives 0011, 32 gives 1111.
- R7: `core_count` equals 32 divided by the register count (4, 2 or 1). It also reads at debug address 1057, and writes to that address are ignored.
- R8: A pipeline read of a register in a disabled bank returns zero. A pipeline write to such a register is dropped, and the register keeps its old value.
- R9: While `run` is 1, writes to address 1056 are ignored, and `bank_en` and `core_count` do not change. They are not applied later when `run` falls.
- R10: Suppose a 0x5 debug write to 1024+n and a pipeline write with `wr_addr` = n happen in the same cycle. Then the pipeline data is stored and the debug data is discarded. `dbg_err` is 1 in the following cycle only, once per such cycle.
- R11: A synchronous active-low reset clears every register and `dbg_err`, sets the count to 32, enables all four banks and sets `core_count` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Program running; locks the configuration |
| rd_addr_a | input | 5 | Pipeline read port A register number |
| rd_data_a | output | 32 | Pipeline read port A data |
| rd_addr_b | input | 5 | Pipeline read port B register number |
| rd_data_b | output | 32 | Pipeline read port B data |
| wr_en | input | 1 | Pipeline write enable |
| wr_addr | input | 5 | Pipeline write register number |
| wr_data | input | 32 | Pipeline write data |
| dbg_op | input | 4 | Debug operation code (0x4 read, 0x5 write) |
| dbg_addr | input | 16 | Debug special-register address |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data |
| dbg_err | output | 1 | One-cycle pulse after a debug write lost to a pipeline write |
| bank_en | output | 4 | Per-bank enable, bit k for bank k |
| core_count | output | 3 | Register sets of the current size that fit in the file |

## Verification
The pipeline write port and the debug write port can both commit in the same clock cycle. The bench drives them in one cycle, first to the same register and then to two different registers. In the clash case it judges that the pipeline value is the one read back, and that `dbg_err` rises for the next cycle and falls again. In the other case both values must be read back and no error may appear. Same-cycle forwarding is also provoked, by reading the register being written before the edge.

// File: rtl/srf_pkg.sv
`timescale 1ns/1ps
// Shared constants for the run-time sized register file.
// Assumes a 4-bit debug operation code.
package srf_pkg;
    localparam int unsigned DBG_OP_W = 4;
    localparam logic [DBG_OP_W-1:0] DBG_OP_READ  = 4'h4;
    localparam logic [DBG_OP_W-1:0] DBG_OP_WRITE = 4'h5;
endpackage

// File: rtl/srf_bank.sv
`timescale 1ns/1ps
// One bank of registers with two write ports; port A (pipeline) wins on
// the same entry. HOLD_ZERO makes entry 0 a constant zero (register 0).
// Assumes the caller already masked writes that must not land.
module srf_bank #(
    parameter int BANK_REGS = 8,
    parameter int DATA_W    = 32,
    parameter bit HOLD_ZERO = 1'b0,
    localparam int BIDX_W   = $clog2(BANK_REGS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              pa_we,
    input  logic [BIDX_W-1:0]                 pa_idx,
    input  logic [DATA_W-1:0]                 pa_data,
    input  logic                              pb_we,
    input  logic [BIDX_W-1:0]                 pb_idx,
    input  logic [DATA_W-1:0]                 pb_data,
    output logic [BANK_REGS-1:0][DATA_W-1:0]  q
);
    for (genvar i = 0; i < BANK_REGS; i++) begin : g_ent
        if (HOLD_ZERO && i == 0) begin : g_zero
            assign q[i] = '0;
        end else begin : g_reg
            logic [DATA_W-1:0] r;
            // Entry storage: reset clear, port A has priority over port B.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    r <= '0;
                else if (pa_we && pa_idx == BIDX_W'(i))
                    r <= pa_data;
                else if (pb_we && pb_idx == BIDX_W'(i))
                    r <= pb_data;
            end
            assign q[i] = r;
        end
    end
endmodule

// File: rtl/srf_sizer.sv
`timescale 1ns/1ps
// Configuration holder: turns a requested register count into an enabled
// bank count (power of two), a stored count and a core count.
// Assumes NUM_BANKS and NUM_REGS are powers of two.
module srf_sizer #(
    parameter int NUM_REGS  = 32,
    parameter int NUM_BANKS = 4,
    parameter int DATA_W    = 32,
    localparam int BANK_REGS = NUM_REGS / NUM_BANKS,
    localparam int LOG_T     = $clog2(NUM_REGS),
    localparam int BSEL_W    = $clog2(NUM_BANKS),
    localparam int CNT_W     = LOG_T + 1,
    localparam int CORE_W    = BSEL_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [DATA_W-1:0]    cfg_val,
    output logic [NUM_BANKS-1:0] bank_en,
    output logic [CNT_W-1:0]     reg_count,
    output logic [CORE_W-1:0]    core_count
);
    logic [CORE_W-1:0] nbanks_q;
    logic [CORE_W-1:0] want_banks;
    logic [CORE_W-1:0] want_cores;
    logic              big;

    assign big = |cfg_val[DATA_W-1:LOG_T];

    // Round the request up to a power-of-two bank count and derive cores.
    always_comb begin
        int need;
        int p;
        int c;
        if (big)
            need = NUM_BANKS;
        else
            need = (int'(cfg_val[LOG_T-1:0]) + BANK_REGS - 1) / BANK_REGS;
        if (need < 1)
            need = 1;
        p = 1;
        c = NUM_BANKS;
        for (int i = 0; i < BSEL_W; i++) begin
            if (p < need) begin
                p = p * 2;
                c = c / 2;
            end
        end
        want_banks = CORE_W'(p);
        want_cores = CORE_W'(c);
    end

    // Configuration registers: full file after reset, load on accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nbanks_q   <= CORE_W'(NUM_BANKS);
            reg_count  <= CNT_W'(NUM_REGS);
            core_count <= CORE_W'(1);
        end else if (cfg_we) begin
            nbanks_q   <= want_banks;
            reg_count  <= CNT_W'(int'(want_banks) * BANK_REGS);
            core_count <= want_cores;
        end
    end

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_en
        assign bank_en[k] = (nbanks_q > CORE_W'(k));
    end
endmodule

// File: rtl/srf_rport.sv
`timescale 1ns/1ps
// Combinational read port with register-0 zeroing, an enable gate and
// forwarding from two write sources that land this cycle.
// Assumes the two sources never hit the same register together.
module srf_rport #(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  logic [IDX_W-1:0]                addr,
    input  logic                            gate_ok,
    input  logic                            fa_hit,
    input  logic [IDX_W-1:0]                fa_addr,
    input  logic [DATA_W-1:0]               fa_data,
    input  logic                            fb_hit,
    input  logic [IDX_W-1:0]                fb_addr,
    input  logic [DATA_W-1:0]               fb_data,
    output logic [DATA_W-1:0]               data
);
    // Select zero, forwarded data or stored data.
    always_comb begin
        if (addr == '0 || !gate_ok)
            data = '0;
        else if (fa_hit && fa_addr == addr)
            data = fa_data;
        else if (fb_hit && fb_addr == addr)
            data = fb_data;
        else
            data = regs[addr];
    end
endmodule

// File: rtl/scalable_regfile.sv
`timescale 1ns/1ps
// Run-time sized banked register file: two read ports and one write port
// for the pipeline, a debug port on a special-register window, bank
// enables and a core count derived from a register-count setting.
// Assumes synchronous active-low reset and one debug operation per cycle.
module scalable_regfile #(
    parameter int NUM_REGS   = 32,
    parameter int NUM_BANKS  = 4,
    parameter int DATA_W     = 32,
    parameter int DBG_ADDR_W = 16,
    parameter int WIN_BASE   = 1024,
    parameter int CNT_ADDR   = 1056,
    parameter int CORE_ADDR  = 1057
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run,
    input  logic [$clog2(NUM_REGS)-1:0]   rd_addr_a,
    output logic [DATA_W-1:0]             rd_data_a,
    input  logic [$clog2(NUM_REGS)-1:0]   rd_addr_b,
    output logic [DATA_W-1:0]             rd_data_b,
    input  logic                          wr_en,
    input  logic [$clog2(NUM_REGS)-1:0]   wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [3:0]                    dbg_op,
    input  logic [DBG_ADDR_W-1:0]         dbg_addr,
    input  logic [DATA_W-1:0]             dbg_wdata,
    output logic [DATA_W-1:0]             dbg_rdata,
    output logic                          dbg_err,
    output logic [NUM_BANKS-1:0]          bank_en,
    output logic [$clog2(NUM_BANKS):0]    core_count
);
    import srf_pkg::*;

    localparam int IDX_W     = $clog2(NUM_REGS);
    localparam int BANK_REGS = NUM_REGS / NUM_BANKS;
    localparam int BSEL_W    = $clog2(NUM_BANKS);
    localparam int BIDX_W    = $clog2(BANK_REGS);
    localparam int CNT_W     = IDX_W + 1;

    logic [NUM_REGS-1:0][DATA_W-1:0] regs;
    logic [DBG_ADDR_W-1:0] dbg_off;
    logic [IDX_W-1:0]      dbg_idx;
    logic                  win_hit, is_rd, is_wr;
    logic                  clash, pipe_land, dbg_land, cfg_we;
    logic [CNT_W-1:0]      reg_count;
    logic [DATA_W-1:0]     win_data;

    // Debug address decode.
    assign dbg_off = dbg_addr - DBG_ADDR_W'(WIN_BASE);
    assign win_hit = (dbg_addr >= DBG_ADDR_W'(WIN_BASE))
                     && (dbg_off < DBG_ADDR_W'(NUM_REGS));
    assign dbg_idx = dbg_off[IDX_W-1:0];
    assign is_rd   = (dbg_op == DBG_OP_READ);
    assign is_wr   = (dbg_op == DBG_OP_WRITE);

    // Write arbitration: pipeline lands only in an enabled bank, debug
    // loses on a same-register clash, register 0 never lands.
    assign clash     = is_wr && win_hit && wr_en && (wr_addr == dbg_idx);
    assign pipe_land = wr_en && (wr_addr != '0)
                       && bank_en[wr_addr[IDX_W-1 -: BSEL_W]];
    assign dbg_land  = is_wr && win_hit && (dbg_idx != '0) && !clash;
    assign cfg_we    = is_wr && !run && (dbg_addr == DBG_ADDR_W'(CNT_ADDR));

    srf_sizer #(
        .NUM_REGS (NUM_REGS),
        .NUM_BANKS(NUM_BANKS),
        .DATA_W   (DATA_W)
    ) u_sizer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_val   (dbg_wdata),
        .bank_en   (bank_en),
        .reg_count (reg_count),
        .core_count(core_count)
    );

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        logic [BANK_REGS-1:0][DATA_W-1:0] q;
        srf_bank #(
            .BANK_REGS(BANK_REGS),
            .DATA_W   (DATA_W),
            .HOLD_ZERO(k == 0)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .pa_we  (pipe_land && wr_addr[IDX_W-1 -: BSEL_W] == BSEL_W'(k)),
            .pa_idx (wr_addr[BIDX_W-1:0]),
            .pa_data(wr_data),
            .pb_we  (dbg_land && dbg_idx[IDX_W-1 -: BSEL_W] == BSEL_W'(k)),
            .pb_idx (dbg_idx[BIDX_W-1:0]),
            .pb_data(dbg_wdata),
            .q      (q)
        );
        assign regs[k*BANK_REGS +: BANK_REGS] = q;
    end

    srf_rport #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_a (
        .regs(regs), .addr(rd_addr_a),
        .gate_ok(bank_en[rd_addr_a[IDX_W-1 -: BSEL_W]]),
        .fa_hit(pipe_land), .fa_addr(wr_addr), .fa_data(wr_data),
        .fb_hit(dbg_land), .fb_addr(dbg_idx), .fb_data(dbg_wdata),
        .data(rd_data_a)
    );

    srf_rport #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_b (
        .regs(regs), .addr(rd_addr_b),
        .gate_ok(bank_en[rd_addr_b[IDX_W-1 -: BSEL_W]]),
        .fa_hit(pipe_land), .fa_addr(wr_addr), .fa_data(wr_data),
        .fb_hit(dbg_land), .fb_addr(dbg_idx), .fb_data(dbg_wdata),
        .data(rd_data_b)
    );

    srf_rport #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_dbg (
        .regs(regs), .addr(dbg_idx), .gate_ok(1'b1),
        .fa_hit(pipe_land), .fa_addr(wr_addr), .fa_data(wr_data),
        .fb_hit(1'b0), .fb_addr(dbg_idx), .fb_data(dbg_wdata),
        .data(win_data)
    );

    // Debug read mux: window, count setting, core count.
    always_comb begin
        if (!is_rd)
            dbg_rdata = '0;
        else if (win_hit)
            dbg_rdata = win_data;
        else if (dbg_addr == DBG_ADDR_W'(CNT_ADDR))
            dbg_rdata = DATA_W'(reg_count);
        else if (dbg_addr == DBG_ADDR_W'(CORE_ADDR))
            dbg_rdata = DATA_W'(core_count);
        else
            dbg_rdata = '0;
    end

    // Error pulse one cycle after a lost debug write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dbg_err <= 1'b0;
        else
            dbg_err <= clash;
    end
endmodule

// File: rtl/srf_checker.sv
`timescale 1ns/1ps
// Property checker for scalable_regfile, attached by bind.
// Assumes the default window base of the top module.
module srf_checker #(
    parameter int NUM_REGS   = 32,
    parameter int NUM_BANKS  = 4,
    parameter int DATA_W     = 32,
    parameter int DBG_ADDR_W = 16,
    parameter int WIN_BASE   = 1024,
    localparam int IDX_W     = $clog2(NUM_REGS),
    localparam int BSEL_W    = $clog2(NUM_BANKS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   run,
    input logic [IDX_W-1:0]       rd_addr_a,
    input logic [DATA_W-1:0]      rd_data_a,
    input logic [IDX_W-1:0]       rd_addr_b,
    input logic [DATA_W-1:0]      rd_data_b,
    input logic                   wr_en,
    input logic [IDX_W-1:0]       wr_addr,
    input logic [3:0]             dbg_op,
    input logic [DBG_ADDR_W-1:0]  dbg_addr,
    input logic [DATA_W-1:0]      dbg_rdata,
    input logic                   dbg_err,
    input logic [NUM_BANKS-1:0]   bank_en,
    input logic [BSEL_W:0]        core_count
);
    logic [DBG_ADDR_W-1:0] off;
    logic                  lost_wr;
    assign off = dbg_addr - DBG_ADDR_W'(WIN_BASE);
    assign lost_wr = (dbg_op == 4'h5) && (dbg_addr >= DBG_ADDR_W'(WIN_BASE))
                     && (off < DBG_ADDR_W'(NUM_REGS)) && wr_en
                     && (wr_addr == off[IDX_W-1:0]);

    a_r2_zero_port_a: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr_a == '0 |-> rd_data_a == '0);
    a_r2_zero_port_b: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr_b == '0 |-> rd_data_b == '0);
    a_r4_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_op != 4'h4 |-> dbg_rdata == '0);
    a_r6_low_banks: assert property (@(posedge clk) disable iff (!rst_n)
        bank_en[0] && (((bank_en + 1'b1) & bank_en) == '0));
    a_r7_core_times_banks: assert property (@(posedge clk) disable iff (!rst_n)
        int'(core_count) * $countones(bank_en) == NUM_BANKS);
    a_r8_gated_read_a: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_en[rd_addr_a[IDX_W-1 -: BSEL_W]] |-> rd_data_a == '0);
    a_r9_run_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(bank_en) && $stable(core_count));
    a_r10_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lost_wr |=> dbg_err);
    a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lost_wr |=> !dbg_err);
endmodule

bind scalable_regfile srf_checker #(
    .NUM_REGS  (NUM_REGS),
    .NUM_BANKS (NUM_BANKS),
    .DATA_W    (DATA_W),
    .DBG_ADDR_W(DBG_ADDR_W),
    .WIN_BASE  (WIN_BASE)
) u_srf_checker (
    .clk(clk), .rst_n(rst_n), .run(run),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .dbg_op(dbg_op), .dbg_addr(dbg_addr), .dbg_rdata(dbg_rdata),
    .dbg_err(dbg_err), .bank_en(bank_en), .core_count(core_count)
);

// File: tb/tb_scalable_regfile.sv
`timescale 1ns/1ps
// Self-checking bench: a write/read vector table, then directed tests.
module tb_scalable_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [31:0] rd_data_a, rd_data_b, wr_data = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  dbg_op = '0;
    logic [15:0] dbg_addr = '0;
    logic [31:0] dbg_wdata = '0, dbg_rdata;
    logic        dbg_err;
    logic [3:0]  bank_en;
    logic [2:0]  core_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    scalable_regfile dut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dbg_op(dbg_op), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
        .dbg_rdata(dbg_rdata), .dbg_err(dbg_err),
        .bank_en(bank_en), .core_count(core_count)
    );

    // {register number, data}; register 0 must read back as zero.
    localparam logic [36:0] VEC [0:7] = '{
        {5'd1,  32'h1111_0001}, {5'd7,  32'h7777_0007},
        {5'd8,  32'h8888_0008}, {5'd12, 32'hC0DE_000C},
        {5'd15, 32'hF0F0_000F}, {5'd16, 32'h1616_0010},
        {5'd31, 32'h3131_001F}, {5'd0,  32'hDEAD_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pw(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #0.5;
        wr_en = 1'b0;
    endtask

    task automatic dw(input logic [15:0] a, input logic [31:0] d, input logic [3:0] op);
        @(negedge clk);
        dbg_op = op; dbg_addr = a; dbg_wdata = d;
        @(posedge clk); #0.5;
        dbg_op = 4'h0;
    endtask

    task automatic dr(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        dbg_op = 4'h4; dbg_addr = a;
        #0.5 d = dbg_rdata;
        dbg_op = 4'h0;
    endtask

    task automatic pr(input logic [4:0] a, output logic [31:0] da, output logic [31:0] db);
        @(negedge clk);
        rd_addr_a = a; rd_addr_b = a;
        #0.5 da = rd_data_a; db = rd_data_b;
    endtask

    task automatic cfg(input logic [31:0] v, input logic [31:0] ecnt,
                       input logic [3:0] een, input logic [2:0] ecore);
        logic [31:0] r;
        dw(16'd1056, v, 4'h5);
        chk("R6 bank_en after count write", 32'(bank_en), 32'(een));
        chk("R7 core_count after count write", 32'(core_count), 32'(ecore));
        dr(16'd1056, r);
        chk("R5 count readback", r, ecnt);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state.
        #0.5;
        chk("R11 bank_en reset", 32'(bank_en), 32'hF);
        chk("R11 core_count reset", 32'(core_count), 32'd1);
        chk("R11 dbg_err reset", 32'(dbg_err), 32'd0);
        dr(16'd1056, d);
        chk("R11 count reset", d, 32'd32);
        pr(5'd5, a, b);
        chk("R11 register cleared", a, 32'd0);

        // R1, R2, R4: vector table walk.
        for (int i = 0; i < 8; i++) begin
            logic [4:0]  ra;
            logic [31:0] rv, ex;
            ra = VEC[i][36:32];
            rv = VEC[i][31:0];
            ex = (ra == 5'd0) ? 32'd0 : rv;
            pw(ra, rv);
            pr(ra, a, b);
            chk("R1 table read port A", a, ex);
            chk("R1 table read port B", b, ex);
            dr(16'd1024 + 16'(ra), d);
            chk("R4 table debug read", d, ex);
        end

        // R3: forwarding of a write landing this cycle.
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd9; wr_data = 32'hABCD_0009; rd_addr_a = 5'd9;
        #0.5 chk("R3 forward before edge", rd_data_a, 32'hABCD_0009);
        @(posedge clk); #0.5 wr_en = 1'b0;

        // R2: debug write to register 0 has no effect.
        dw(16'd1024, 32'h5555_AAAA, 4'h5);
        dr(16'd1024, d);
        chk("R2 debug write r0 ignored", d, 32'd0);

        // R4: debug write, then a non-read/write code changes nothing.
        dw(16'd1030, 32'h0606_0606, 4'h5);
        dw(16'd1030, 32'hBAD0_0006, 4'h6);
        dr(16'd1030, d);
        chk("R4 other code ignored", d, 32'h0606_0606);
        @(negedge clk);
        dbg_op = 4'h6; dbg_addr = 16'd1030;
        #0.5 chk("R4 rdata zero for other code", dbg_rdata, 32'd0);
        dbg_op = 4'h0;

        // R5, R6, R7: rounding of the requested count.
        cfg(32'd5,   32'd8,  4'b0001, 3'd4);
        cfg(32'd9,   32'd16, 4'b0011, 3'd2);
        cfg(32'd17,  32'd32, 4'b1111, 3'd1);
        cfg(32'd0,   32'd8,  4'b0001, 3'd4);
        cfg(32'd100, 32'd32, 4'b1111, 3'd1);
        cfg(32'd16,  32'd16, 4'b0011, 3'd2);
        cfg(32'd24,  32'd32, 4'b1111, 3'd1);
        cfg(32'd8,   32'd8,  4'b0001, 3'd4);
        dr(16'd1057, d);
        chk("R7 core count via debug", d, 32'd4);
        dw(16'd1057, 32'd1, 4'h5);
        chk("R7 core count write ignored", 32'(core_count), 32'd4);

        // R8: bank 1 disabled; reads zero, writes dropped, debug still sees it.
        pr(5'd12, a, b);
        chk("R8 disabled read A", a, 32'd0);
        chk("R8 disabled read B", b, 32'd0);
        dr(16'd1036, d);
        chk("R4 debug ignores bank enable", d, 32'hC0DE_000C);
        pw(5'd12, 32'h0BAD_BAD0);
        pr(5'd7, a, b);
        chk("R8 enabled bank still readable", a, 32'h7777_0007);
        cfg(32'd32, 32'd32, 4'b1111, 3'd1);
        pr(5'd12, a, b);
        chk("R8 disabled write dropped", a, 32'hC0DE_000C);

        // R9: run locks the configuration, no deferred apply.
        @(negedge clk); run = 1'b1;
        dw(16'd1056, 32'd8, 4'h5);
        chk("R9 bank_en frozen", 32'(bank_en), 32'hF);
        chk("R9 core_count frozen", 32'(core_count), 32'd1);
        @(negedge clk); run = 1'b0;
        @(posedge clk); #0.5;
        chk("R9 no deferred apply", 32'(bank_en), 32'hF);
        dr(16'd1056, d);
        chk("R9 count unchanged", d, 32'd32);

        // R10: same-register clash, pipeline wins, one-cycle error pulse.
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd7; wr_data = 32'hA5A5_0007;
        dbg_op = 4'h5; dbg_addr = 16'd1031; dbg_wdata = 32'h5A5A_0007;
        @(posedge clk); #0.5;
        wr_en = 1'b0; dbg_op = 4'h0;
        chk("R10 error raised", 32'(dbg_err), 32'd1);
        @(posedge clk); #0.5;
        chk("R10 error one cycle", 32'(dbg_err), 32'd0);
        pr(5'd7, a, b);
        chk("R10 pipeline data kept", a, 32'hA5A5_0007);

        // R10: different registers in the same cycle, both land, no error.
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd20; wr_data = 32'h2020_2020;
        dbg_op = 4'h5; dbg_addr = 16'd1045; dbg_wdata = 32'h2121_2121;
        @(posedge clk); #0.5;
        wr_en = 1'b0; dbg_op = 4'h0;
        chk("R10 no error on distinct registers", 32'(dbg_err), 32'd0);
        pr(5'd20, a, b);
        chk("R10 pipeline write landed", a, 32'h2020_2020);
        pr(5'd21, a, b);
        chk("R10 debug write landed", a, 32'h2121_2121);

        // R11: reset mid-run restores the defaults.
        cfg(32'd8, 32'd8, 4'b0001, 3'd4);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #0.5;
        chk("R11 bank_en after second reset", 32'(bank_en), 32'hF);
        pr(5'd7, a, b);
        chk("R11 registers cleared again", a, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule